// File: doc/BRIEF.md
# Multi-Lane Reversible Column Shift Register

This block is a 192-stage serial-in, parallel-out shift register that feeds the column outputs of a display driver. Serial data arrives on up to six input lanes. The stages are interleaved among the active lanes, so each lane fills every third, fourth or sixth stage. A two-bit mode input chooses the lane count and the interleave pattern. One mode splits the array into two halves, and each half is filled by its own group of three lanes.

A direction input reverses the fill order inside every lane. An edge-select input chooses whether the external shift clock advances the chain on its rising edge only, or on both of its edges. The shift clock, data, mode, direction and edge-select inputs are sampled into a faster system clock through two-flop synchronisers. A level-change detector then turns each qualifying shift clock edge into a one-cycle strobe, so double-edge operation needs only ordinary flip-flops. An active-low clear, synchronous to the system clock, empties the array. The whole array is presented as a 192-bit parallel word. Latching, blanking and output drive belong to the logic that follows this block.

Top module: `disp_lane_shifter`

## Requirements
- R1: With mode_sel = 2'b00 (three lanes, 64 stages per lane), stage bit i (0-based) belongs to lane i mod 3, and lanes 3 to 5 take no part.
- R2: With mode_sel = 2'b01 (four lanes, 48 stages per lane), stage bit i belongs to lane i mod 4, and lanes 4 and 5 take no part.
- R3: With mode_sel = 2'b10 (six lanes, 32 stages per lane), stage bit i belongs to lane i mod 6.
- R4: With mode_sel = 2'b11 (split, 32 stages per lane), lane i mod 3 fills bits 0 to 95 at stride 3, and lane 3 + (i - 96) mod 3 fills bits 96 to 191 at stride 3.
- R5: With shift_right = 1, each lane's input enters at the lowest stage of that lane and older data moves up one lane position. With shift_right = 0, the input enters at the highest stage of the lane (its group, in split mode) and older data moves down.
- R6: With edge_both = 0, only a rising edge of shclk_in shifts and a falling edge leaves the array unchanged. With edge_both = 1, every rising edge and every falling edge shifts once.
- R7: When clr_n is low at a system clock edge, all stages become 0 at that edge. This takes priority over a shift strobe in the same cycle.
- R8: In the three-lane and four-lane modes, the values on the unused lane inputs have no effect on the stages.
- R9: A change of mode_sel or shift_right leaves the stored stages unchanged. The new setting applies from the next shift onward.
- R10: A synchronous active-high rst clears all stages and the synchronisers.
- R11: Without a qualifying shift clock edge and without clear, the stages hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| shclk_in | input | 1 | External shift clock, asynchronous |
| edge_both | input | 1 | 0: shift on rising edge only; 1: shift on both edges |
| shift_right | input | 1 | 1: fill from the low end of each lane; 0: fill from the high end |
| mode_sel | input | 2 | Lane layout: 00 three lanes, 01 four lanes, 10 six lanes, 11 split 3+3 |
| lane_in | input | 6 | Serial data lanes, bit k is lane k |
| clr_n | input | 1 | Active-low clear, synchronous to clk |
| stages | output | 192 | Parallel stage contents, bit i is stage i |

## Verification
The bench fills the array completely in every mode and in both directions, and compares it against a lane-chain model. A wrong stride or a wrong group boundary puts bits on the wrong stages, and in split mode it lets data cross between bits 95 and 96. Unused lanes are driven with random values, so a design that let them into the chain would corrupt the three-lane and four-lane results. Falling edges with single-edge mode selected catch a detector that shifts twice per clock period. Changing the mode and direction with no clock edge, and asserting clear in the same cycle as a strobe, catch a design that reshuffles its contents on reconfiguration or lets a shift win over clear.

// File: rtl/disp_shift_pkg.sv
package disp_shift_pkg;

  typedef enum logic [1:0] {
    MODE_TRI   = 2'b00,
    MODE_QUAD  = 2'b01,
    MODE_HEX   = 2'b10,
    MODE_SPLIT = 2'b11
  } lane_mode_e;

  localparam int NUM_MODES = 4;

  // Lane stride (stages between neighbours of one lane) for a mode number.
  function automatic int stride_for(input int m);
    case (m)
      0:       return 3;
      1:       return 4;
      2:       return 6;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/strobe_gen.sv
module strobe_gen (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic both_s,
  output logic strobe
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sclk_s;
  end

  always_comb strobe = (sclk_s & ~prev_q) | (both_s & ~sclk_s & prev_q);

  // R6: a falling shift clock never shifts in single-edge mode
  p_no_fall_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (!both_s && $fell(sclk_s)) |-> !strobe);

  // R6: every level change shifts in double-edge mode
  p_dual_edge_r6: assert property (@(posedge clk) disable iff (rst)
    (both_s && ($rose(sclk_s) || $fell(sclk_s))) |-> strobe);
endmodule

// File: rtl/stage_array.sv
module stage_array
  import disp_shift_pkg::*;
#(
  parameter int NUM_STAGES = 192,
  parameter int NUM_LANES  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_n,
  input  logic                  strobe,
  input  logic                  shift_right,
  input  lane_mode_e            mode,
  input  logic [NUM_LANES-1:0]  lane_d,
  output logic [NUM_STAGES-1:0] q
);
  localparam int HALF     = NUM_STAGES / 2;
  localparam int HALF_LN  = NUM_LANES / 2;

  logic [NUM_MODES-1:0][NUM_STAGES-1:0] nxt_up;
  logic [NUM_MODES-1:0][NUM_STAGES-1:0] nxt_dn;
  logic [NUM_STAGES-1:0]                next_word;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      localparam int STR   = stride_for(m);
      localparam bit UPPER = (m == int'(MODE_SPLIT)) && (i >= HALF);
      localparam int BASE  = UPPER ? HALF : 0;
      localparam int GLEN  = (m == int'(MODE_SPLIT)) ? HALF : NUM_STAGES;
      localparam int REL   = i - BASE;
      localparam int LANE  = (UPPER ? HALF_LN : 0) + (REL % STR);

      if (REL < STR) begin : g_head
        assign nxt_up[m][i] = lane_d[LANE];
      end else begin : g_body_up
        assign nxt_up[m][i] = q[i-STR];
      end

      if (REL >= GLEN - STR) begin : g_tail
        assign nxt_dn[m][i] = lane_d[LANE];
      end else begin : g_body_dn
        assign nxt_dn[m][i] = q[i+STR];
      end
    end
  end

  always_comb next_word = shift_right ? nxt_up[mode] : nxt_dn[mode];

  always_ff @(posedge clk) begin
    if (rst || !clr_n) q <= '0;
    else if (strobe)   q <= next_word;
  end

  // R7: clear empties the array and beats a coincident strobe
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (q == '0));

  // R11: no strobe, no change
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !strobe) |=> $stable(q));

  // R1: three-lane upward shift moves every stage up by three
  p_tri_up_r1: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe && shift_right && mode == MODE_TRI) |=>
      (q[NUM_STAGES-1:3] == $past(q[NUM_STAGES-4:0])) && (q[2:0] == $past(lane_d[2:0])));

  // R4: split downward shift loads both group tops from their own lanes
  p_split_down_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && strobe && !shift_right && mode == MODE_SPLIT) |=>
      (q[HALF-1:HALF-3] == $past(lane_d[2:0])) &&
      (q[NUM_STAGES-1:NUM_STAGES-3] == $past(lane_d[NUM_LANES-1:NUM_LANES-3])));
endmodule

// File: rtl/disp_lane_shifter.sv
module disp_lane_shifter
  import disp_shift_pkg::*;
#(
  parameter int NUM_STAGES = 192,
  parameter int NUM_LANES  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shclk_in,
  input  logic                  edge_both,
  input  logic                  shift_right,
  input  logic [1:0]            mode_sel,
  input  logic [NUM_LANES-1:0]  lane_in,
  input  logic                  clr_n,
  output logic [NUM_STAGES-1:0] stages
);
  localparam int SYNC_W = NUM_LANES + 5;

  logic [SYNC_W-1:0] sync_s;
  logic              strobe;
  lane_mode_e        mode_s;

  sync_bank #(.WIDTH(SYNC_W)) i_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({mode_sel, shift_right, edge_both, shclk_in, lane_in}),
    .sync_out (sync_s)
  );

  assign mode_s = lane_mode_e'(sync_s[SYNC_W-1 -: 2]);

  strobe_gen i_strobe (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (sync_s[NUM_LANES]),
    .both_s (sync_s[NUM_LANES+1]),
    .strobe (strobe)
  );

  stage_array #(.NUM_STAGES(NUM_STAGES), .NUM_LANES(NUM_LANES)) i_array (
    .clk         (clk),
    .rst         (rst),
    .clr_n       (clr_n),
    .strobe      (strobe),
    .shift_right (sync_s[NUM_LANES+2]),
    .mode        (mode_s),
    .lane_d      (sync_s[NUM_LANES-1:0]),
    .q           (stages)
  );
endmodule

// File: tb/test_disp_lane_shifter.sv
module test_disp_lane_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 192;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shclk_in = 1'b0;
  logic         edge_both = 1'b0;
  logic         shift_right = 1'b1;
  logic [1:0]   mode_sel = 2'b00;
  logic [5:0]   lane_in = '0;
  logic         clr_n = 1'b1;
  logic [N-1:0] stages;

  int           checks = 0;
  int           errors = 0;
  bit           finished = 0;
  logic [N-1:0] model = '0;
  logic [15:0]  lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_lane_shifter i_disp_lane_shifter (
    .clk(clk), .rst(rst), .shclk_in(shclk_in), .edge_both(edge_both),
    .shift_right(shift_right), .mode_sel(mode_sel), .lane_in(lane_in),
    .clr_n(clr_n), .stages(stages)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rnd(output logic [5:0] v);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    v = lfsr[5:0];
  endtask

  // Lane-chain model: walk each lane's chain from one end to the other.
  task automatic model_shift(input logic [5:0] din);
    int stride, groups, glen, chain, lane, base;
    stride = (mode_sel == 2'b01) ? 4 : (mode_sel == 2'b10) ? 6 : 3;
    groups = (mode_sel == 2'b11) ? 2 : 1;
    glen   = N / groups;
    chain  = glen / stride;
    for (int g = 0; g < groups; g++) begin
      for (int k = 0; k < stride; k++) begin
        lane = g * stride + k;
        base = g * glen + k;
        if (shift_right) begin
          for (int j = chain - 1; j > 0; j--) model[base + j*stride] = model[base + (j-1)*stride];
          model[base] = din[lane];
        end else begin
          for (int j = 0; j < chain - 1; j++) model[base + j*stride] = model[base + (j+1)*stride];
          model[base + (chain-1)*stride] = din[lane];
        end
      end
    end
  endtask

  task automatic step(input logic [5:0] din, input logic lvl);
    @(negedge clk);
    lane_in = din;
    repeat (3) @(negedge clk);
    shclk_in = lvl;
    repeat (6) @(negedge clk);
    if (lvl || edge_both) model_shift(din);
  endtask

  task automatic set_cfg(input logic [1:0] md, input logic right, input logic both);
    @(negedge clk);
    mode_sel = md;
    shift_right = right;
    edge_both = both;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R10 reset state", stages, '0);
  endtask

  task automatic t_tri_up;
    logic [5:0] v;
    set_cfg(2'b00, 1'b1, 1'b0);
    for (int s = 0; s < 64; s++) begin
      rnd(v);
      step(v, 1'b1);
      rnd(v);
      step(v, 1'b0);
      if (s < 4) check("R6 falling edge ignored in single-edge mode", stages, model);
    end
    check("R1 R5 R8 three-lane upward fill", stages, model);
  endtask

  task automatic t_quad_down;
    logic [5:0] v;
    set_cfg(2'b01, 1'b0, 1'b0);
    for (int s = 0; s < 48; s++) begin
      rnd(v);
      step(v, 1'b1);
      rnd(v);
      step(v, 1'b0);
    end
    check("R2 R5 R8 four-lane downward fill", stages, model);
  endtask

  task automatic t_hex_dual;
    logic [5:0] v;
    set_cfg(2'b10, 1'b1, 1'b1);
    for (int s = 0; s < 32; s++) begin
      rnd(v);
      step(v, ~shclk_in);
      if (s == 1) check("R6 both edges shift in double-edge mode", stages, model);
    end
    check("R3 six-lane double-edge fill", stages, model);
  endtask

  task automatic t_split;
    logic [5:0] v;
    set_cfg(2'b11, 1'b1, 1'b1);
    for (int s = 0; s < 32; s++) begin
      rnd(v);
      step(v, ~shclk_in);
    end
    check("R4 split upward fill", stages, model);
    set_cfg(2'b11, 1'b0, 1'b1);
    check("R9 direction change keeps contents", stages, model);
    for (int s = 0; s < 10; s++) begin
      rnd(v);
      step(v, ~shclk_in);
    end
    check("R4 R5 split downward shift", stages, model);
  endtask

  task automatic t_mode_change;
    logic [5:0] v;
    set_cfg(2'b01, 1'b1, 1'b1);
    check("R9 mode change keeps contents", stages, model);
    rnd(v);
    step(v, ~shclk_in);
    check("R9 new mode applies on next shift", stages, model);
  endtask

  task automatic t_hold;
    repeat (30) @(negedge clk);
    check("R11 hold without clock edge", stages, model);
  endtask

  task automatic t_clear;
    set_cfg(2'b00, 1'b1, 1'b0);
    if (shclk_in) step(6'h15, 1'b0);
    check("R11 nonzero before clear", (stages == '0) ? '0 : model, model);
    @(negedge clk);
    clr_n = 1'b0;
    lane_in = 6'h3F;
    shclk_in = 1'b1;
    repeat (6) @(negedge clk);
    clr_n = 1'b1;
    model = '0;
    check("R7 clear overrides coincident shift", stages, model);
    step(6'h3F, 1'b0);
    check("R7 stays empty after clear", stages, model);
    step(6'h3F, 1'b1);
    check("R7 shifting resumes after clear", stages, model);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_tri_up();
    t_quad_down();
    t_hex_dual();
    t_split();
    t_mode_change();
    t_hold();
    t_clear();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule